// File: doc/BRIEF.md
# Intermittent-Clock Register Crossing Bridge

This block sits between a register bank that is clocked only while an external serial master is toggling its clock, and logic running on a free-running system clock. On the serial side it accepts a write strobe, a register index and a data byte. It keeps the written bytes, which can be read back at once through a combinational read port. Each configuration register carries a phase bit that flips on every write. The system side watches each phase bit through a synchronizer. When the bit changes, it copies the register into a shadow output and pulses an update flag for one system cycle. No acknowledge travels back, because the serial clock may stop at any moment for any length of time.

Results travel the other way through a polled handshake. A request bit in the control register reaches the system domain through two flops. The system side captures the result bytes presented on its input and, one cycle later, raises a ready flag. That flag is brought back through two flops clocked by the serial clock and appears as a status bit. The master polls this bit before it reads the result bytes. A second control bit drives a reset output for the system-domain logic around the bridge. The software convention is to change configuration only while that reset is held.

Top module: `regx_bridge`

## Requirements
- R1: While rst_n is low and after its release with no writes, every shadow byte, every update flag and every read-port byte is zero, and sys_soft_rst_o is high during reset and low after it.
- R2: A write strobed on a rising serial edge to index k, with 1 <= k <= NREG, stores the byte in configuration register k. The byte reads back at index k right after that edge.
- R3: Every write to configuration register k yields exactly one update pulse on upd_o[k-1], one system cycle wide, and no pulse on any other register, provided writes to the same register are at least four system cycles apart.
- R4: shadow byte k-1 (bits 8(k-1)+7..8(k-1) of shadow_o) changes only in a system cycle where upd_o[k-1] is high. During that pulse it equals the last byte written to register k, even when the same value is written again.
- R5: Control register index 0 holds bit 0 as the read request and bit 1 as the system reset request. sys_soft_rst_o follows bit 1 from the serial edge that writes it, and the register reads back as those two bits with the upper bits zero.
- R6: Once the synchronized request is seen, the system side captures res_data_i into the result bytes and raises ready one cycle later. The result bytes then hold, whatever res_data_i does, while the request stays set.
- R7: The system side clears ready when it sees the request cleared. A later request captures res_data_i afresh and raises ready again.
- R8: Index NREG+1 reads the ready flag in bit 0 with the other bits zero. The flag reaches this status bit only through two serial-clock edges, and does not change while the serial clock is stopped.
- R9: Writes to the status index, to result indices or to any index above NREG+NRES+1 change no stored byte, produce no update pulse and leave every read-port value as it was.
- R10: Index NREG+2+j reads result byte j, which is captured from bits 8j+7..8j of res_data_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ser | input | 1 | Intermittent serial-side clock; rising edge stores writes |
| clk_sys | input | 1 | Free-running system clock |
| rst_n | input | 1 | Global asynchronous reset, active low |
| wr_en | input | 1 | Write strobe, sampled on the rising edge of clk_ser |
| wr_idx | input | IDX_W | Register index for the write |
| wr_data | input | 8 | Byte to write |
| rd_idx | input | IDX_W | Register index for the combinational read port |
| rd_data | output | 8 | Byte at rd_idx as seen from the serial side |
| res_data_i | input | NRES*8 | Result bytes offered by system-domain logic |
| shadow_o | output | NREG*8 | System-domain copies of the configuration registers, byte k-1 for register k |
| upd_o | output | NREG | One-cycle update pulse per shadow byte |
| sys_soft_rst_o | output | 1 | Reset for system-domain logic, high during global reset or while control bit 1 is set |

## Verification
The assertions assume that one configuration register is not rewritten within four system cycles. They also assume that res_data_i is valid by the time the request reaches the system side, and that the wr_* inputs settle before a serial rising edge. The stimulus writes each vector in its own short burst of serial clock pulses. Between bursts it waits eight system cycles with the serial clock stopped, so every crossing finishes before the next write to the same register. Back-to-back writes go only to different registers. The result bytes are applied before the request is written and are changed only after capture, which exercises the hold rule.

// File: rtl/regx_bridge_pkg.sv
package regx_bridge_pkg;
    localparam int DW         = 8;
    localparam int CTRL_W     = 2;
    localparam int CTRL_REQ   = 0;
    localparam int CTRL_SRST  = 1;
    typedef logic [DW-1:0] rbyte_t;
endpackage

// File: rtl/regx_ser_bank.sv
module regx_ser_bank
    import regx_bridge_pkg::*;
#(
    parameter int NREG  = 4,
    parameter int NRES  = 2,
    parameter int IDX_W = 4
) (
    input  logic                clk_ser,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [IDX_W-1:0]    wr_idx,
    input  logic [DW-1:0]       wr_data,
    input  logic [IDX_W-1:0]    rd_idx,
    output logic [DW-1:0]       rd_data,
    input  logic [NRES*DW-1:0]  res_flat_i,
    input  logic                rdy_sys_i,
    output logic [NREG*DW-1:0]  cfg_flat_o,
    output logic [NREG-1:0]     phase_o,
    output logic                req_o,
    output logic                srst_o
);
    localparam int STAT_IDX = NREG + 1;
    localparam int RES_BASE = NREG + 2;

    typedef struct packed {
        logic [NREG-1:0][DW-1:0] cfg;
        logic [NREG-1:0]         phase;
        logic [CTRL_W-1:0]       ctrl;
        logic                    rdy_s1;
        logic                    rdy_s2;
    } ser_st_t;

    ser_st_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        st_d.rdy_s1 = rdy_sys_i;
        st_d.rdy_s2 = st_q.rdy_s1;
        if (wr_en) begin
            if (wr_idx == '0) begin
                st_d.ctrl = wr_data[CTRL_W-1:0];
            end
            for (int k = 0; k < NREG; k++) begin
                if (int'(wr_idx) == k + 1) begin
                    st_d.cfg[k]   = wr_data;
                    st_d.phase[k] = ~st_q.phase[k];
                end
            end
        end
    end

    always_ff @(posedge clk_ser or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        rd_data = '0;
        if (rd_idx == '0) begin
            rd_data[CTRL_W-1:0] = st_q.ctrl;
        end
        for (int k = 0; k < NREG; k++) begin
            if (int'(rd_idx) == k + 1) rd_data = st_q.cfg[k];
        end
        if (int'(rd_idx) == STAT_IDX) begin
            rd_data[0] = st_q.rdy_s2;
        end
        for (int j = 0; j < NRES; j++) begin
            if (int'(rd_idx) == RES_BASE + j) rd_data = res_flat_i[j*DW +: DW];
        end
    end

    assign cfg_flat_o = st_q.cfg;
    assign phase_o    = st_q.phase;
    assign req_o      = st_q.ctrl[CTRL_REQ];
    assign srst_o     = st_q.ctrl[CTRL_SRST];
endmodule

// File: rtl/regx_phase_xfer.sv
module regx_phase_xfer
    import regx_bridge_pkg::*;
(
    input  logic          clk_sys,
    input  logic          rst_n,
    input  logic          phase_i,
    input  logic [DW-1:0] data_i,
    output logic [DW-1:0] shadow_o,
    output logic          upd_o
);
    typedef struct packed {
        logic          s1;
        logic          s2;
        logic          s3;
        logic [DW-1:0] shadow;
        logic          upd;
    } px_st_t;

    px_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.s1  = phase_i;
        st_d.s2  = st_q.s1;
        st_d.s3  = st_q.s2;
        st_d.upd = st_q.s2 ^ st_q.s3;
        if (st_q.s2 != st_q.s3) begin
            st_d.shadow = data_i;
        end
    end

    always_ff @(posedge clk_sys or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign shadow_o = st_q.shadow;
    assign upd_o    = st_q.upd;
endmodule

// File: rtl/regx_rd_handshake.sv
module regx_rd_handshake
    import regx_bridge_pkg::*;
#(
    parameter int NRES = 2
) (
    input  logic               clk_sys,
    input  logic               rst_n,
    input  logic               req_i,
    input  logic [NRES*DW-1:0] res_data_i,
    output logic               req_seen_o,
    output logic               rdy_o,
    output logic [NRES*DW-1:0] res_o
);
    typedef struct packed {
        logic              req_s1;
        logic              req_s2;
        logic              cap_done;
        logic              rdy;
        logic [NRES*DW-1:0] res;
    } hs_st_t;

    hs_st_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        st_d.req_s1 = req_i;
        st_d.req_s2 = st_q.req_s1;
        if (!st_q.req_s2) begin
            st_d.cap_done = 1'b0;
            st_d.rdy      = 1'b0;
        end else if (!st_q.cap_done) begin
            st_d.res      = res_data_i;
            st_d.cap_done = 1'b1;
        end else begin
            st_d.rdy      = 1'b1;
        end
    end

    always_ff @(posedge clk_sys or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign req_seen_o = st_q.req_s2;
    assign rdy_o      = st_q.rdy;
    assign res_o      = st_q.res;
endmodule

// File: rtl/regx_bridge.sv
module regx_bridge
    import regx_bridge_pkg::*;
#(
    parameter int NREG  = 4,
    parameter int NRES  = 2,
    parameter int IDX_W = 4
) (
    input  logic               clk_ser,
    input  logic               clk_sys,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [IDX_W-1:0]   wr_idx,
    input  logic [7:0]         wr_data,
    input  logic [IDX_W-1:0]   rd_idx,
    output logic [7:0]         rd_data,
    input  logic [NRES*8-1:0]  res_data_i,
    output logic [NREG*8-1:0]  shadow_o,
    output logic [NREG-1:0]    upd_o,
    output logic               sys_soft_rst_o
);
    logic [NREG*DW-1:0] cfg_flat;
    logic [NREG-1:0]    phase;
    logic               req_ser;
    logic               srst_ser;
    logic               req_sys;
    logic               rdy_sys;
    logic [NRES*DW-1:0] res_q;

    regx_ser_bank #(.NREG(NREG), .NRES(NRES), .IDX_W(IDX_W)) u_bank (
        .clk_ser    (clk_ser),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_idx     (wr_idx),
        .wr_data    (wr_data),
        .rd_idx     (rd_idx),
        .rd_data    (rd_data),
        .res_flat_i (res_q),
        .rdy_sys_i  (rdy_sys),
        .cfg_flat_o (cfg_flat),
        .phase_o    (phase),
        .req_o      (req_ser),
        .srst_o     (srst_ser)
    );

    for (genvar k = 0; k < NREG; k++) begin : g_xfer
        regx_phase_xfer u_xfer (
            .clk_sys  (clk_sys),
            .rst_n    (rst_n),
            .phase_i  (phase[k]),
            .data_i   (cfg_flat[k*DW +: DW]),
            .shadow_o (shadow_o[k*DW +: DW]),
            .upd_o    (upd_o[k])
        );
    end

    regx_rd_handshake #(.NRES(NRES)) u_hs (
        .clk_sys    (clk_sys),
        .rst_n      (rst_n),
        .req_i      (req_ser),
        .res_data_i (res_data_i),
        .req_seen_o (req_sys),
        .rdy_o      (rdy_sys),
        .res_o      (res_q)
    );

    assign sys_soft_rst_o = ~rst_n | srst_ser;
endmodule

// File: rtl/regx_bridge_chk.sv
module regx_bridge_chk #(
    parameter int NREG  = 4,
    parameter int NRES  = 2,
    parameter int IDX_W = 4
) (
    input logic              clk_ser,
    input logic              clk_sys,
    input logic              rst_n,
    input logic              wr_en,
    input logic [IDX_W-1:0]  wr_idx,
    input logic [7:0]        wr_data,
    input logic [NREG*8-1:0] cfg_flat,
    input logic [NREG*8-1:0] shadow_o,
    input logic [NREG-1:0]   upd_o,
    input logic              req_sys,
    input logic              rdy_sys,
    input logic [NRES*8-1:0] res_q
);
    for (genvar k = 0; k < NREG; k++) begin : g_chk
        // R2: a strobed write lands in its configuration register
        a_r2_cfg_store: assert property (@(posedge clk_ser) disable iff (!rst_n)
            (wr_en && int'(wr_idx) == k + 1) |=> (cfg_flat[k*8 +: 8] == $past(wr_data)));
        // R4: a shadow byte moves only together with its update pulse
        a_r4_shadow_on_pulse: assert property (@(posedge clk_sys) disable iff (!rst_n)
            (shadow_o[k*8 +: 8] != $past(shadow_o[k*8 +: 8])) |-> upd_o[k]);
        // R3: update pulse lasts a single system cycle
        a_r3_pulse_single: assert property (@(posedge clk_sys) disable iff (!rst_n)
            upd_o[k] |=> !upd_o[k]);
    end

    // R9: writes beyond the configuration range leave the bank untouched
    a_r9_no_stray_write: assert property (@(posedge clk_ser) disable iff (!rst_n)
        (wr_en && int'(wr_idx) > NREG) |=> $stable(cfg_flat));
    // R6: results are already settled whenever ready is high
    a_r6_ready_stable_data: assert property (@(posedge clk_sys) disable iff (!rst_n)
        rdy_sys |-> $stable(res_q));
    // R7: a withdrawn request drops ready
    a_r7_ready_drops: assert property (@(posedge clk_sys) disable iff (!rst_n)
        !req_sys |=> !rdy_sys);
endmodule

bind regx_bridge regx_bridge_chk #(.NREG(NREG), .NRES(NRES), .IDX_W(IDX_W)) u_chk (
    .clk_ser  (clk_ser),
    .clk_sys  (clk_sys),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_idx   (wr_idx),
    .wr_data  (wr_data),
    .cfg_flat (cfg_flat),
    .shadow_o (shadow_o),
    .upd_o    (upd_o),
    .req_sys  (req_sys),
    .rdy_sys  (rdy_sys),
    .res_q    (res_q)
);

// File: tb/regx_bridge_tb_top.sv
module regx_bridge_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NREG  = 4;
    localparam int NRES  = 2;
    localparam int IDX_W = 4;
    localparam int STAT  = NREG + 1;
    localparam int RBASE = NREG + 2;
    localparam int NVEC  = 9;
    // {index[11:8], data[7:0]}
    localparam logic [11:0] VEC [NVEC] = '{
        12'h1A5, 12'h23C, 12'h3FF, 12'h400, 12'h181,
        12'h17E, 12'h4C3, 12'h4C3, 12'h201
    };

    logic              clk_ser = 1'b0;
    logic              clk_sys = 1'b0;
    logic              rst_n   = 1'b0;
    logic              wr_en   = 1'b0;
    logic [IDX_W-1:0]  wr_idx  = '0;
    logic [7:0]        wr_data = '0;
    logic [IDX_W-1:0]  rd_idx  = '0;
    logic [7:0]        rd_data;
    logic [NRES*8-1:0] res_data_i = '0;
    logic [NREG*8-1:0] shadow_o;
    logic [NREG-1:0]   upd_o;
    logic              sys_soft_rst_o;

    int checks   = 0;
    int failures = 0;
    int pulse_cnt [NREG];
    int snap      [NREG];
    logic [NREG-1:0] upd_prev = '0;
    logic [7:0] exp_cfg [NREG];

    regx_bridge #(.NREG(NREG), .NRES(NRES), .IDX_W(IDX_W)) dut_i (.*);

    always #(CLK_PERIOD/2) clk_sys = ~clk_sys;

    initial begin
        for (int k = 0; k < NREG; k++) pulse_cnt[k] = 0;
    end

    always @(negedge clk_sys) begin
        for (int k = 0; k < NREG; k++) begin
            if (upd_o[k]) begin
                pulse_cnt[k]++;
                if (upd_prev[k]) begin
                    failures++;
                    $display("FAIL R3 pulse wider than one cycle reg %0d act=1 exp=0", k + 1);
                end
            end
        end
        upd_prev = upd_o;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic ser_write(input int idx, input logic [7:0] d);
        wr_idx  = IDX_W'(idx);
        wr_data = d;
        wr_en   = 1'b1;
        #3 clk_ser = 1'b1;
        #4 clk_ser = 1'b0;
        wr_en = 1'b0;
        #3;
    endtask

    task automatic ser_tick();
        #3 clk_ser = 1'b1;
        #4 clk_ser = 1'b0;
        #3;
    endtask

    task automatic rd(input int idx, output logic [7:0] d);
        rd_idx = IDX_W'(idx);
        #1 d = rd_data;
    endtask

    task automatic sys_wait(input int n);
        repeat (n) @(negedge clk_sys);
    endtask

    task automatic take_snap();
        for (int k = 0; k < NREG; k++) snap[k] = pulse_cnt[k];
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        failures++;
        $display("FAIL watchdog act=timeout exp=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [7:0] v;
        for (int k = 0; k < NREG; k++) exp_cfg[k] = 8'h00;

        // R1: reset state
        sys_wait(3);
        chk("R1 soft reset during reset", 32'(sys_soft_rst_o), 1);
        chk("R1 shadow in reset", 32'(shadow_o), 0);
        chk("R1 upd in reset", 32'(upd_o), 0);
        rst_n = 1'b1;
        sys_wait(3);
        chk("R1 soft reset after release", 32'(sys_soft_rst_o), 0);
        for (int i = 0; i < RBASE + NRES; i++) begin
            rd(i, v);
            chk("R1 read port zero", 32'(v), 0);
        end

        // R2 R3 R4: vector walk
        for (int i = 0; i < NVEC; i++) begin
            int idx;
            logic [7:0] d;
            idx = int'(VEC[i][11:8]);
            d   = VEC[i][7:0];
            take_snap();
            sys_wait(1);
            ser_write(idx, d);
            exp_cfg[idx-1] = d;
            rd(idx, v);
            chk("R2 readback", 32'(v), 32'(d));
            sys_wait(8);
            for (int k = 0; k < NREG; k++) begin
                chk("R3 pulse count", 32'(pulse_cnt[k] - snap[k]), (k == idx - 1) ? 1 : 0);
                chk("R4 shadow value", 32'(shadow_o[k*8 +: 8]), 32'(exp_cfg[k]));
            end
        end

        // R3: back-to-back writes to different registers
        take_snap();
        ser_write(2, 8'h11);
        ser_write(3, 8'h22);
        exp_cfg[1] = 8'h11;
        exp_cfg[2] = 8'h22;
        sys_wait(8);
        chk("R3 b2b pulse reg2", 32'(pulse_cnt[1] - snap[1]), 1);
        chk("R3 b2b pulse reg3", 32'(pulse_cnt[2] - snap[2]), 1);
        chk("R4 b2b shadow reg2", 32'(shadow_o[15:8]), 32'h11);
        chk("R4 b2b shadow reg3", 32'(shadow_o[23:16]), 32'h22);

        // R9: stray writes ignored
        take_snap();
        ser_write(STAT, 8'hFF);
        ser_write(RBASE, 8'hFF);
        ser_write(15, 8'hFF);
        sys_wait(8);
        for (int k = 0; k < NREG; k++) begin
            chk("R9 no pulse", 32'(pulse_cnt[k] - snap[k]), 0);
            chk("R9 shadow kept", 32'(shadow_o[k*8 +: 8]), 32'(exp_cfg[k]));
            rd(k + 1, v);
            chk("R9 cfg kept", 32'(v), 32'(exp_cfg[k]));
        end
        rd(STAT, v);  chk("R9 status kept", 32'(v), 0);
        rd(RBASE, v); chk("R9 result kept", 32'(v), 0);
        rd(15, v);    chk("R9 unused reads zero", 32'(v), 0);

        // R6 R8 R10: request and poll
        res_data_i = 16'h3CC3;
        ser_write(0, 8'h01);
        rd(0, v);     chk("R5 ctrl readback", 32'(v), 1);
        rd(STAT, v);  chk("R8 status before ready", 32'(v), 0);
        sys_wait(10);
        rd(STAT, v);  chk("R8 status frozen without serial clock", 32'(v), 0);
        res_data_i = 16'h5555;
        ser_tick();
        rd(STAT, v);  chk("R8 status after one edge", 32'(v), 0);
        ser_tick();
        rd(STAT, v);  chk("R8 status after two edges", 32'(v), 1);
        rd(RBASE, v);     chk("R10 result byte0", 32'(v), 32'hC3);
        rd(RBASE + 1, v); chk("R6 result byte1 held", 32'(v), 32'h3C);

        // R7: withdraw and re-request
        ser_write(0, 8'h00);
        sys_wait(10);
        ser_tick();
        ser_tick();
        rd(STAT, v);  chk("R7 status cleared", 32'(v), 0);
        ser_write(0, 8'h01);
        sys_wait(10);
        ser_tick();
        ser_tick();
        rd(STAT, v);  chk("R7 fresh ready", 32'(v), 1);
        rd(RBASE, v);     chk("R7 fresh byte0", 32'(v), 32'h55);
        rd(RBASE + 1, v); chk("R7 fresh byte1", 32'(v), 32'h55);

        // R5: system reset bit
        ser_write(0, 8'h02);
        chk("R5 soft reset set", 32'(sys_soft_rst_o), 1);
        rd(0, v);     chk("R5 ctrl upper bits zero", 32'(v), 2);
        ser_write(0, 8'hFC);
        chk("R5 soft reset cleared", 32'(sys_soft_rst_o), 0);
        rd(0, v);     chk("R5 ctrl masked", 32'(v), 0);

        sys_wait(4);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule